// File: doc/BRIEF.md
# Dual-Bank Set/Clear GPIO Controller

This block controls 32 general-purpose pins through a 32-bit register port. The pins are split into two banks of 16: pins 0-15 form the low bank and pins 16-31 the high bank. Each bank has its own copy of six per-pin feature registers: output value, output enable, input enable, output alternate-function select A, output alternate-function select B and input alternate-function select. Each bank also has a read-only input-status word.

A register is never rewritten as a whole word. The low half of a write word sets bits, the high half clears bits, and a zero in either half leaves the bit alone. Because of this, two agents can change different pins of the same register without a read-modify-write sequence. A pin is driven only when its output enable is on and neither output alternate-function select is on. Inputs reach the register port through a two-stage synchroniser. To use a pin as plain GPIO, software clears the three alternate-function selects for that pin and then sets the output enable or the input enable.

Top module: `gpio_dual_bank`

## Requirements
- R1: While rst_ni is low, and after it is released, every register bit is 0, pin_o and pin_oe_o are 0 and rdata_o is 0.
- R2: A write with data bit k = 1 (k in 0..15) sets bit k of the addressed register in the addressed bank. The register takes the new value at the clock edge that samples we_i.
- R3: A write with data bit k+16 = 1 clears bit k of the addressed register. Register bits whose set and clear data bits are both 0 keep their value.
- R4: When a write has both the set bit and the clear bit of a pin at 1, the register bit becomes 0.
- R5: Byte address bit 7 selects the bank. Addresses 0x00-0x7F reach pins 0-15 and addresses 0x80-0xFF reach pins 16-31, with bank-local pin k on data bit k.
- R6: Word offsets inside a bank: 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C output alternate A, 0x10 output alternate B, 0x14 input alternate, 0x18 input status (read-only).
- R7: rdata_o is registered. It shows the word at the address sampled on the previous clock edge, with the bank's 16 bits on bits 15:0 and zeros on bits 31:16.
- R8: The register bits of pins 23, 29, 30 and 31 stay 0 under any write, so those pins never drive and always read 0.
- R9: pin_o carries the output value register of each pin. pin_oe_o[n] is 1 only when output enable n is 1 and both output alternate selects n are 0.
- R10: The input status returns pin_i passed through two flip-flops and ANDed with the input enable. A pin change shows in rdata_o for a read held at the status offset after the third rising edge.
- R11: An address not aligned to 4 bytes, or a word offset of 0x1C or above inside a bank, reads 0 and is not changed by a write. A write to the input-status offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address for both read and write |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write word: set mask in 15:0, clear mask in 31:16 |
| rdata_o | output | 32 | Registered read word |
| pin_i | input | 32 | Pin input levels (asynchronous) |
| pin_o | output | 32 | Pin output levels |
| pin_oe_o | output | 32 | Pin drive enables, 0 means high impedance |

## Verification
Register writes take effect at the edge that samples we_i. From that edge, pin_o and pin_oe_o change with no further delay, so the bench checks them half a period after that edge. A read-back needs one more edge, because the read address is sampled into the rdata_o register. The bench therefore presents the read address in the cycle after the write and checks rdata_o half a period after the next edge. The input path adds two synchroniser edges in front of the read register. The bench shows this with a held status read: after two edges the old value is still expected, and after the third edge the new value.

// File: rtl/gpio_dual_bank_pkg.sv
package gpio_dual_bank_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_W    = 16;
  localparam int unsigned NUM_FEAT  = 6;
  localparam int unsigned STAT_IDX  = NUM_FEAT;

  typedef enum logic [2:0] {
    FEAT_OUT_VAL = 3'd0,
    FEAT_OUT_EN  = 3'd1,
    FEAT_IN_EN   = 3'd2,
    FEAT_OALT_A  = 3'd3,
    FEAT_OALT_B  = 3'd4,
    FEAT_IALT    = 3'd5
  } feat_e;

  typedef logic [BANK_W-1:0] bank_word_t;
endpackage

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] KEEP_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // clear has priority over set
  always_comb q_d = ((q_o | set_i) & ~clr_i) & KEEP_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= q_d;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_dual_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output logic [NUM_FEAT-1:0]  feat_sel_o,
  output logic                 stat_sel_o
);
  localparam int unsigned BANK_BIT = ADDR_W - 1;
  localparam int unsigned IDX_W    = BANK_BIT - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[BANK_BIT-1:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel_o[b] = (addr_i[BANK_BIT] == 1'(b));
  end

  for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
    assign feat_sel_o[f] = aligned && (idx == IDX_W'(f));
  end

  assign stat_sel_o = aligned && (idx == IDX_W'(STAT_IDX));
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] RSVD_MASK = 32'hE080_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       pin_i,
  output logic [31:0]       pin_o,
  output logic [31:0]       pin_oe_o
);
  localparam int unsigned NPINS = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_FEAT-1:0]  feat_sel;
  logic                 stat_sel;
  logic [NPINS-1:0]     pin_sync;
  bank_word_t           feat_q [NUM_BANKS][NUM_FEAT];
  bank_word_t           bank_rd [NUM_BANKS];
  bank_word_t           rd_word;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .bank_sel_o (bank_sel),
    .feat_sel_o (feat_sel),
    .stat_sel_o (stat_sel)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bank_word_t KEEP = ~RSVD_MASK[b*BANK_W +: BANK_W];

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
      gpio_sc_reg #(.W(BANK_W), .KEEP_MASK(KEEP)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (we_i && bank_sel[b] && feat_sel[f]),
        .set_i  (wdata_i[BANK_W-1:0]),
        .clr_i  (wdata_i[2*BANK_W-1:BANK_W]),
        .q_o    (feat_q[b][f])
      );
    end

    assign pin_o[b*BANK_W +: BANK_W]    = feat_q[b][FEAT_OUT_VAL];
    assign pin_oe_o[b*BANK_W +: BANK_W] = feat_q[b][FEAT_OUT_EN]
                                        & ~feat_q[b][FEAT_OALT_A]
                                        & ~feat_q[b][FEAT_OALT_B];

    always_comb begin
      bank_rd[b] = '0;
      for (int f = 0; f < NUM_FEAT; f++)
        if (feat_sel[f]) bank_rd[b] = bank_rd[b] | feat_q[b][f];
      if (stat_sel)
        bank_rd[b] = bank_rd[b]
                   | (pin_sync[b*BANK_W +: BANK_W] & feat_q[b][FEAT_IN_EN] & KEEP);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b]) rd_word = rd_word | bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= {{(32-BANK_W){1'b0}}, rd_word};
  end
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] RSVD_MASK = 32'hE080_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       pin_o,
  input logic [31:0]       pin_oe_o
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && pin_oe_o == '0 && rdata_o == '0));

  // R2
  a_r2_set_low_outval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && wdata_i[31:16] == '0)
    |=> ((pin_o[15:0] & $past(wdata_i[15:0])) == $past(wdata_i[15:0])));

  // R3
  a_r3_zero_write_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == '0) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  // R4
  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && wdata_i == 32'hFFFF_FFFF) |=> (pin_o[15:0] == '0));

  // R7
  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:16] == '0);

  // R8
  a_r8_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o | pin_oe_o) & RSVD_MASK) == '0);

  // R11
  a_r11_misaligned_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00) |=> (rdata_o == '0));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.ADDR_W(ADDR_W), .RSVD_MASK(RSVD_MASK)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/gpio_dual_bank_test.sv
module gpio_dual_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_dual_bank uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .we_i     (we),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pin_i    (pin_in),
    .pin_o    (pin_out),
    .pin_oe_o (pin_oe)
  );

  // {write addr, write data, read addr, expected read, tag}
  localparam int NV = 12;
  localparam logic [79:0] VEC [NV] = '{
    {8'h00, 32'h0000_00F0, 8'h00, 32'h0000_00F0},  // R2 set
    {8'h00, 32'h0030_0001, 8'h00, 32'h0000_00C1},  // R3 clear + set
    {8'h00, 32'h0001_0001, 8'h00, 32'h0000_00C0},  // R4 clear wins
    {8'h80, 32'h0000_FFFF, 8'h80, 32'h0000_1F7F},  // R5/R8 high bank, reserved
    {8'h80, 32'h0F00_0000, 8'h80, 32'h0000_107F},  // R3 high clear
    {8'h80, 32'h0000_0000, 8'h00, 32'h0000_00C0},  // R5 banks separate
    {8'h04, 32'h0000_00FF, 8'h04, 32'h0000_00FF},  // R6 output enable
    {8'h0C, 32'h0000_0003, 8'h0C, 32'h0000_0003},  // R6 alt A
    {8'h10, 32'h0000_0004, 8'h10, 32'h0000_0004},  // R6 alt B
    {8'h14, 32'h0000_8000, 8'h14, 32'h0000_8000},  // R6 input alt
    {8'h08, 32'hFFFF_A5A5, 8'h08, 32'h0000_0000},  // R4 all-ones write
    {8'h40, 32'h0000_FFFF, 8'h40, 32'h0000_0000}   // R11 unmapped
  };
  localparam string VTAG [NV] = '{"R2","R3","R4","R8","R3","R5",
                                  "R6","R6","R6","R6","R4","R11"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  // sets address at a negedge, returns value registered at the next edge
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pin_oe, 32'h0);
    check("R1 out in reset", pin_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); check("R1 outval after reset", v, 32'h0);
    rd(8'h84, v); check("R1 high oe after reset", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], v);
      check(VTAG[i], v, VEC[i][31:0]);
    end

    // restore input enable low bank
    wr(8'h08, 32'h0000_A5A5);
    rd(8'h08, v); check("R2 input enable", v, 32'h0000_A5A5);

    // R11 misaligned write ignored, reads zero
    wr(8'h02, 32'h0000_FFFF);
    rd(8'h02, v); check("R11 misaligned read", v, 32'h0);
    rd(8'h00, v); check("R11 misaligned write ignored", v, 32'h0000_00C0);
    rd(8'h1C, v); check("R11 offset 0x1C reads zero", v, 32'h0);
    wr(8'h18, 32'h0000_FFFF);
    rd(8'h00, v); check("R11 status write ignored", v, 32'h0000_00C0);

    // R9 pin drive
    check("R9 pin_o", pin_out, 32'h107F_00C0);
    check("R9 pin_oe", pin_oe, 32'h0000_00F8);

    // R8 reserved high OE
    wr(8'h84, 32'h0000_FFFF);
    check("R8 reserved oe", pin_oe, 32'h1F7F_00F8);
    wr(8'h84, 32'h0080_0000);
    check("R8 reserved clear no effect", pin_oe, 32'h1F7F_00F8);

    // R10 input path
    pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(8'h18, v); check("R10 status masked by enable", v, 32'h0000_A5A5);
    rd(8'h98, v); check("R10 high status disabled", v, 32'h0);
    addr = 8'h18;
    repeat (2) @(negedge clk);
    pin_in = 32'h0;
    @(negedge clk);
    @(negedge clk);
    check("R10 old value after two edges", rdata, 32'h0000_A5A5);
    @(negedge clk);
    check("R10 new value after third edge", rdata, 32'h0);
    wr(8'h88, 32'h0000_FFFF);
    pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(8'h98, v); check("R10 high status reserved", v, 32'h0000_1F7F);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset out", pin_out, 32'h0);
    check("R1 async reset oe", pin_oe, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(8'h80, v); check("R1 high outval cleared", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule